// File: doc/BRIEF.md
# Descriptor-Chained Transmit Page DMA

This block moves outgoing frames from a packet memory organised in 256-byte pages into a transmit FIFO. A start pulse latches a page number. The engine reads the four-byte descriptor at the head of that page. If the ownership flag is set, it streams the frame's payload bytes into the FIFO. The payload begins right after the descriptor and runs across page boundaries inside a configurable ring of pages. The engine then writes the descriptor's status byte back with the ownership flag cleared.

Each descriptor carries a link to the page of the next frame. A link that points back at the frame's own page ends the run, so one start command can send either a single frame or a whole chain. A descriptor still owned by software halts the run at once: no payload is sent and a not-owned flag is raised. The end of every run is marked by a one-cycle done pulse.

The engine has one memory access in flight at a time. It uses a request/grant handshake that both reads and writes go through, and it holds back whenever the FIFO reports full.

Top module: `tx_page_dma`

## Requirements
- R1: On an accepted start, the first memory read is the head of page `start_page_i`. The descriptor byte order is fixed: offset 0 is status, offset 1 is the next-frame page, offset 2 is the length low byte and offset 3 is the length high byte.
- R2: When status bit 7 (ownership) is 1, exactly `length` payload bytes are pushed into the FIFO, in address order, starting at offset 4 of the frame's page.
- R3: When status bit 7 is 0, the run ends with no FIFO push and no memory write, and `not_owned_o` reads 1 until the next accepted start.
- R4: When the next-frame page equals the page of the frame just sent, the run ends after that frame. `done_o` is high for exactly one cycle and `busy_o` falls in the same cycle.
- R5: When the next-frame page differs from the current page, the engine goes on to the descriptor at that page without a new start.
- R6: A payload read that passes offset 255 continues at offset 0 of the following page. The page that follows `ring_stop_i - 1` is `ring_start_i`.
- R7: After a frame's payload, the status byte at offset 0 of its page is rewritten with bit 7 cleared and all other bits unchanged. This happens before any further descriptor read.
- R8: No byte is pushed while `fifo_full_i` is high, and stalls lose or repeat no byte.
- R9: A raised `mem_req_o` keeps its address until `mem_gnt_i`. Read data is taken from `mem_rdata_i` in the cycle after the grant.
- R10: A start pulse while `busy_o` is high is ignored.
- R11: A frame with length 0 pushes nothing but still gets its status write-back.
- R12: After reset, `busy_o`, `done_o`, `mem_req_o`, `fifo_push_o` and `not_owned_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| start_page_i | input | 8 | Page of the first descriptor |
| ring_start_i | input | 8 | First page of the transmit ring |
| ring_stop_i | input | 8 | Page just beyond the last ring page |
| mem_req_o | output | 1 | Memory access request |
| mem_gnt_i | input | 1 | Memory grant for the current request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 16 | Byte address {page, offset} |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after grant |
| fifo_push_o | output | 1 | Push one byte into the FIFO |
| fifo_data_o | output | 8 | Byte being pushed |
| fifo_full_i | input | 1 | FIFO cannot accept a byte |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| not_owned_o | output | 1 | The last run stopped on a software-owned descriptor |

## Verification
The assertions take for granted that the memory answers a granted read in the next cycle and changes `mem_gnt_i` only between clock edges. They also assume that ring start and stop stay constant during a run, with start below stop and every frame page inside the ring. The stimulus keeps within this. A behavioural memory returns data one cycle after each grant, and grant and FIFO-full are driven on the falling edge, with patterns that are either always open or sparse. Ring settings change only while the engine is idle.

// File: rtl/tx_page_dma_pkg.sv
package tx_page_dma_pkg;

    localparam int DESC_BYTES = 4;
    localparam int OWN_BIT    = 7;

    typedef enum logic [2:0] {
        TD_IDLE,
        TD_DESC_RD,
        TD_DESC_CAP,
        TD_PAY_RD,
        TD_PAY_CAP,
        TD_PUSH,
        TD_WBACK
    } td_state_e;

endpackage

// File: rtl/tdma_page_step.sv
module tdma_page_step #(
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W-1:0] cur_i,
    input  logic [PAGE_W-1:0] ring_start_i,
    input  logic [PAGE_W-1:0] ring_stop_i,
    output logic [PAGE_W-1:0] next_o
);
    logic [PAGE_W-1:0] inc;

    always_comb begin
        inc    = cur_i + 1'b1;
        next_o = (inc == ring_stop_i) ? ring_start_i : inc;
    end
endmodule

// File: rtl/tdma_ptr_adv.sv
module tdma_ptr_adv #(
    parameter int PAGE_W = 8,
    parameter int OFF_W  = 8
) (
    input  logic [PAGE_W-1:0] page_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [PAGE_W-1:0] ring_start_i,
    input  logic [PAGE_W-1:0] ring_stop_i,
    output logic [PAGE_W-1:0] page_o,
    output logic [OFF_W-1:0]  off_o
);
    logic [PAGE_W-1:0] stepped;

    tdma_page_step #(.PAGE_W(PAGE_W)) u_step (
        .cur_i        (page_i),
        .ring_start_i (ring_start_i),
        .ring_stop_i  (ring_stop_i),
        .next_o       (stepped)
    );

    always_comb begin
        off_o  = off_i + 1'b1;
        page_o = (&off_i) ? stepped : page_i;
    end
endmodule

// File: rtl/tx_page_dma.sv
module tx_page_dma
    import tx_page_dma_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int OFF_W  = 8,
    parameter int LEN_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [PAGE_W-1:0]         start_page_i,
    input  logic [PAGE_W-1:0]         ring_start_i,
    input  logic [PAGE_W-1:0]         ring_stop_i,
    output logic                      mem_req_o,
    input  logic                      mem_gnt_i,
    output logic                      mem_we_o,
    output logic [PAGE_W+OFF_W-1:0]   mem_addr_o,
    output logic [7:0]                mem_wdata_o,
    input  logic [7:0]                mem_rdata_i,
    output logic                      fifo_push_o,
    output logic [7:0]                fifo_data_o,
    input  logic                      fifo_full_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic                      not_owned_o
);
    localparam int ADDR_W = PAGE_W + OFF_W;
    localparam logic [OFF_W-1:0] PAY_OFF = OFF_W'(DESC_BYTES);

    typedef struct packed {
        td_state_e         st;
        logic [1:0]        idx;
        logic [PAGE_W-1:0] page;
        logic [PAGE_W-1:0] link;
        logic [PAGE_W-1:0] ppage;
        logic [OFF_W-1:0]  poff;
        logic [7:0]        status;
        logic [LEN_W-1:0]  remain;
        logic [7:0]        hold;
        logic              done;
        logic              not_owned;
    } regs_t;

    regs_t r_q, r_d;

    logic [PAGE_W-1:0] adv_page;
    logic [OFF_W-1:0]  adv_off;

    tdma_ptr_adv #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_adv (
        .page_i       (r_q.ppage),
        .off_i        (r_q.poff),
        .ring_start_i (ring_start_i),
        .ring_stop_i  (ring_stop_i),
        .page_o       (adv_page),
        .off_o        (adv_off)
    );

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        fifo_push_o = 1'b0;

        unique case (r_q.st)
            TD_IDLE: begin
                if (start_i) begin
                    r_d.st        = TD_DESC_RD;
                    r_d.page      = start_page_i;
                    r_d.idx       = '0;
                    r_d.not_owned = 1'b0;
                end
            end
            TD_DESC_RD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = {r_q.page, OFF_W'(r_q.idx)};
                if (mem_gnt_i) r_d.st = TD_DESC_CAP;
            end
            TD_DESC_CAP: begin
                r_d.idx = r_q.idx + 1'b1;
                r_d.st  = TD_DESC_RD;
                case (r_q.idx)
                    2'd0: begin
                        r_d.status = mem_rdata_i;
                        if (!mem_rdata_i[OWN_BIT]) begin
                            r_d.st        = TD_IDLE;
                            r_d.not_owned = 1'b1;
                            r_d.done      = 1'b1;
                        end
                    end
                    2'd1: r_d.link = mem_rdata_i[PAGE_W-1:0];
                    2'd2: r_d.remain = LEN_W'(mem_rdata_i);
                    default: begin
                        r_d.remain = LEN_W'({mem_rdata_i, r_q.remain[7:0]});
                        r_d.ppage  = r_q.page;
                        r_d.poff   = PAY_OFF;
                        r_d.st     = ({mem_rdata_i, r_q.remain[7:0]} == 16'd0)
                                     ? TD_WBACK : TD_PAY_RD;
                    end
                endcase
            end
            TD_PAY_RD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = {r_q.ppage, r_q.poff};
                if (mem_gnt_i) r_d.st = TD_PAY_CAP;
            end
            TD_PAY_CAP: begin
                r_d.hold = mem_rdata_i;
                r_d.st   = TD_PUSH;
            end
            TD_PUSH: begin
                if (!fifo_full_i) begin
                    fifo_push_o = 1'b1;
                    r_d.remain  = r_q.remain - 1'b1;
                    r_d.ppage   = adv_page;
                    r_d.poff    = adv_off;
                    r_d.st      = (r_q.remain == LEN_W'(1)) ? TD_WBACK : TD_PAY_RD;
                end
            end
            TD_WBACK: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = {r_q.page, {OFF_W{1'b0}}};
                mem_wdata_o = r_q.status & ~(8'd1 << OWN_BIT);
                if (mem_gnt_i) begin
                    if (r_q.link == r_q.page) begin
                        r_d.st   = TD_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.page = r_q.link;
                        r_d.idx  = '0;
                        r_d.st   = TD_DESC_RD;
                    end
                end
            end
            default: r_d.st = TD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= TD_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign fifo_data_o = r_q.hold;
    assign busy_o      = (r_q.st != TD_IDLE);
    assign done_o      = r_q.done;
    assign not_owned_o = r_q.not_owned;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R4
    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R4
    AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == TD_PUSH && fifo_full_i) |=> (r_q.st == TD_PUSH && $stable(fifo_data_o))); // R8
    AST_WRITE_AT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> (mem_addr_o[OFF_W-1:0] == '0)); // R7
    AST_UNOWNED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        not_owned_o |-> (!fifo_push_o && !mem_we_o)); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_req_o && !fifo_push_o)); // R10
    AST_START_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (mem_req_o && mem_addr_o == {$past(start_page_i), {OFF_W{1'b0}}})); // R1

endmodule

// File: tb/tb_tx_page_dma.sv
module tb_tx_page_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  start_page_i = '0;
    logic [7:0]  ring_start_i = 8'd2;
    logic [7:0]  ring_stop_i  = 8'd8;
    logic        mem_req_o, mem_gnt_i, mem_we_o;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_wdata_o, mem_rdata_i;
    logic        fifo_push_o, fifo_full_i;
    logic [7:0]  fifo_data_o;
    logic        busy_o, done_o, not_owned_o;

    always #4 clk = ~clk;

    tx_page_dma dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_page_i(start_page_i),
        .ring_start_i(ring_start_i), .ring_stop_i(ring_stop_i),
        .mem_req_o(mem_req_o), .mem_gnt_i(mem_gnt_i), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .fifo_push_o(fifo_push_o), .fifo_data_o(fifo_data_o), .fifo_full_i(fifo_full_i),
        .busy_o(busy_o), .done_o(done_o), .not_owned_o(not_owned_o)
    );

    logic [7:0]  mem [0:4095];
    logic [7:0]  got [0:1023];
    int          push_n, done_n, wr_n, cyc;
    logic        ld_we = 1'b0;
    logic [11:0] ld_a = '0;
    logic [7:0]  ld_d = '0;
    logic        clr = 1'b0;
    logic        slow_gnt = 1'b0;
    logic        full_en = 1'b0;
    int          checks = 0;
    int          fails = 0;
    bit          finished = 1'b0;

    function automatic logic [7:0] pat(int a);
        return 8'((a * 29 + (a >> 5)) ^ 8'h5A);
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int i = 0; i < 4096; i++) mem[i] <= pat(i);
        end else if (ld_we) begin
            mem[ld_a] <= ld_d;
        end else if (mem_req_o && mem_gnt_i) begin
            if (mem_we_o) mem[mem_addr_o[11:0]] <= mem_wdata_o;
            else          mem_rdata_i <= mem[mem_addr_o[11:0]];
        end
        if (clr) begin
            push_n <= 0; done_n <= 0; wr_n <= 0;
        end else begin
            if (fifo_push_o) begin
                if (push_n < 1024) got[push_n] <= fifo_data_o;
                push_n <= push_n + 1;
            end
            if (done_o) done_n <= done_n + 1;
            if (mem_req_o && mem_gnt_i && mem_we_o) wr_n <= wr_n + 1;
        end
    end

    always @(negedge clk) begin
        mem_gnt_i   <= !slow_gnt || (cyc % 3 == 2);
        fifo_full_i <= full_en && (cyc % 4 < 2);
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic poke(int a, logic [7:0] d);
        @(negedge clk);
        ld_we = 1'b1; ld_a = 12'(a); ld_d = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic desc(int pg, logic [7:0] st, int nx, int len);
        poke(pg * 256, st);
        poke(pg * 256 + 1, 8'(nx));
        poke(pg * 256 + 2, 8'(len));
        poke(pg * 256 + 3, 8'(len >> 8));
    endtask

    task automatic run(int pg);
        int t = 0;
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        start_page_i = 8'(pg);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (busy_o && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 20000, "R4 run ends", t, 0);
        @(negedge clk);
    endtask

    // compare pushed bytes with memory from page pg offset 4, wrapping per R6
    task automatic cmp_bytes(string req, int base, int pg, int len);
        int p = pg;
        int o = 4;
        int bad = 0;
        for (int i = 0; i < len; i++) begin
            if (got[base + i] !== mem[p * 256 + o]) bad++;
            if (o == 255) begin
                o = 0;
                p = (p + 1 == int'(ring_stop_i)) ? int'(ring_start_i) : p + 1;
            end else begin
                o++;
            end
        end
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic t_reset();
        chk(!busy_o && !done_o && !mem_req_o && !fifo_push_o && !not_owned_o,
            "R12 reset outputs", {busy_o, done_o, mem_req_o, fifo_push_o, not_owned_o}, 0);
    endtask

    task automatic t_single();
        desc(3, 8'h85, 3, 10);
        run(3);
        chk(push_n == 10, "R2 byte count", push_n, 10);
        cmp_bytes("R1 R2 byte order", 0, 3, 10);
        chk(mem[3 * 256] == 8'h05, "R7 status cleared", mem[3 * 256], 8'h05);
        chk(done_n == 1, "R4 single done pulse", done_n, 1);
        chk(!not_owned_o, "R2 owned flag", not_owned_o, 0);
    endtask

    task automatic t_chain();
        desc(2, 8'hC0, 4, 5);
        desc(4, 8'h81, 4, 3);
        run(2);
        chk(push_n == 8, "R5 chain count", push_n, 8);
        cmp_bytes("R5 first frame", 0, 2, 5);
        cmp_bytes("R5 second frame", 5, 4, 3);
        chk(mem[2 * 256] == 8'h40 && mem[4 * 256] == 8'h01, "R7 both cleared",
            {mem[2 * 256], mem[4 * 256]}, 16'h4001);
        chk(wr_n == 2, "R7 write count", wr_n, 2);
    endtask

    task automatic t_unowned();
        desc(5, 8'h05, 5, 4);
        run(5);
        chk(push_n == 0, "R3 no push", push_n, 0);
        chk(wr_n == 0, "R3 no write", wr_n, 0);
        chk(not_owned_o, "R3 flag", not_owned_o, 1);
        chk(mem[5 * 256] == 8'h05, "R3 status kept", mem[5 * 256], 8'h05);
    endtask

    task automatic t_wrap();
        desc(7, 8'h80, 7, 300);
        run(7);
        chk(push_n == 300, "R6 wrap count", push_n, 300);
        cmp_bytes("R6 wrap to ring start", 0, 7, 300);
        chk(got[252] === mem[2 * 256], "R6 first byte after wrap", got[252], mem[2 * 256]);
    endtask

    task automatic t_stall();
        int t = 0;
        desc(6, 8'h82, 6, 20);
        desc(5, 8'h00, 5, 4);
        slow_gnt = 1'b1;
        full_en  = 1'b1;
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        start_page_i = 8'd6;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (30) @(negedge clk);
        start_page_i = 8'd5;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (busy_o && t < 20000) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk);
        slow_gnt = 1'b0;
        full_en  = 1'b0;
        chk(push_n == 20, "R8 count under stall", push_n, 20);
        cmp_bytes("R8 R9 bytes under stall", 0, 6, 20);
        chk(done_n == 1, "R10 one run only", done_n, 1);
        chk(!not_owned_o, "R10 second start ignored", not_owned_o, 0);
    endtask

    task automatic t_zero();
        desc(3, 8'h81, 3, 0);
        run(3);
        chk(push_n == 0, "R11 no push", push_n, 0);
        chk(mem[3 * 256] == 8'h01, "R11 status cleared", mem[3 * 256], 8'h01);
        chk(done_n == 1, "R11 done", done_n, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_chain();
        t_unowned();
        t_wrap();
        t_stall();
        t_zero();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule